// File: doc/BRIEF.md
# Divider Configuration Register with Pin and Serial Loading

This block holds the settings for a clock synthesizer's dividers: a 9-bit feedback divide value, a 2-bit output divide code and a 2-bit test field. Downstream divider counters read these registered settings. There are two ways to write them. In pin mode, the divide values on dedicated input pins are captured when an active-low load strobe returns high. In serial mode, the strobe is held high. A frame is then shifted in one bit per serial clock edge and moved into the active settings under a separate transfer control.

The block also drives a test output that exposes the end of the shift chain during serial mode and is held low in pin mode. A master reset gates the synthesizer clock outputs: the true outputs are forced low and the complementary outputs high. The master reset leaves the stored settings untouched. Only the synchronous power-on reset clears the settings.

All strobe, serial clock and transfer inputs are treated as synchronous to the block clock. Their edges are found by comparing each input with its value one clock earlier.

Top module: `divcfg_iface`

## Requirements
- R1: While `rst_n` is low at a clock edge, the shift register and the `m_val`, `n_val` and `t_val` outputs clear to zero, so `test_out` reads 0.
- R2: On the first clock edge at which `pl_n` is high after being low, `m_val` takes `par_m` and `n_val` takes `par_n`, and `t_val` becomes 0.
- R3: While `pl_n` is low, changes on `par_m` and `par_n` leave the outputs unchanged.
- R4: In serial mode (`pl_n` high), each rising edge of `ser_clk` shifts `ser_dat` into bit 0 of a 13-bit shift register. The frame is sent most significant bit first in this order: T[1:0], N[1:0], M[8:0].
- R5: In serial mode, while `ser_ld` is high, each clock edge copies the shift register into the outputs (T from bits 12:11, N from bits 10:9, M from bits 8:0). The outputs therefore take the register contents one cycle after `ser_ld` rises and keep following them while it stays high.
- R6: While `ser_ld` is low, shifting does not change `m_val`, `n_val` or `t_val`.
- R7: `test_out` equals shift-register bit 12 while `pl_n` is high, and is 0 while `pl_n` is low.
- R8: Asserting `mreset` leaves `m_val`, `n_val` and `t_val` unchanged.
- R9: While `mreset` is high, every `fout` bit is 0 and every `fout_b` bit is 1. While it is low, `fout` equals `raw_clk` and `fout_b` is its complement.
- R10: While `pl_n` is low, `ser_clk` edges leave the shift register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| pl_n | input | 1 | Active-low pin load strobe; high selects serial mode |
| par_m | input | 9 | Feedback divide value pins |
| par_n | input | 2 | Output divide code pins |
| ser_clk | input | 1 | Serial shift clock (edge detected) |
| ser_dat | input | 1 | Serial frame data |
| ser_ld | input | 1 | Serial transfer control, level active |
| mreset | input | 1 | Master reset for the output clocks |
| raw_clk | input | 2 | Ungated divider output clocks |
| m_val | output | 9 | Active feedback divide value |
| n_val | output | 2 | Active output divide code |
| t_val | output | 2 | Active test field |
| test_out | output | 1 | Shift-chain end in serial mode, low in pin mode |
| fout | output | 2 | Gated true clock outputs |
| fout_b | output | 2 | Gated complementary clock outputs |

## Verification
The assertions check three things on every cycle: the settings hold steady while the strobe is low, a strobe return captures the pins with a zero test field, and a serial transfer copies exactly the shift-register image. They also check that the shift register is frozen in pin mode. The bench scenarios cover what depends on a sequence of events. These are the bit order of a complete frame, continuous following while the transfer control stays high, a master-reset pulse leaving the stored settings intact, and shift-register contents surviving a pin-mode interval.

// File: rtl/divcfg_pkg.sv
// Shared widths and the settings record for the divider configuration block.
// Assumes the serial frame is ordered T, N, M from its most significant end.
package divcfg_pkg;
    localparam int M_W     = 9;
    localparam int N_W     = 2;
    localparam int T_W     = 2;
    localparam int FRAME_W = T_W + N_W + M_W;

    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_t;
endpackage

// File: rtl/cfg_shift_reg.sv
// Serial frame shift register. Shifts ser_dat into bit 0 on each rising
// edge of ser_clk, seen against its value one clock earlier, in serial mode only.
// Assumes ser_clk is synchronous to clk and stays high or low for at least one clock.
module cfg_shift_reg #(
    parameter int W = divcfg_pkg::FRAME_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_mode,
    input  logic         ser_clk,
    input  logic         ser_dat,
    output logic [W-1:0] sr
);
    logic sclk_q;
    logic shift_en;

    // Track ser_clk one cycle back; during reset, follow the input so that release creates no edge.
    always_ff @(posedge clk) begin
        sclk_q <= ser_clk;
    end

    assign shift_en = ser_mode && ser_clk && !sclk_q;

    // One flop per frame bit: bit 0 takes the serial input, each other bit takes its lower neighbour.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic nxt;
        if (i == 0) begin : g_head
            assign nxt = ser_dat;
        end else begin : g_body
            assign nxt = sr[i-1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n)        sr[i] <= 1'b0;
            else if (shift_en) sr[i] <= nxt;
        end
    end

    AST_SR_FROZEN_PIN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_mode |=> $stable(sr)); // R10
endmodule

// File: rtl/cfg_load_ctrl.sv
// Active settings register. A return of pl_n to high captures the pins with
// T cleared. In serial mode a high ser_ld copies the shift register every clock.
// Assumes pl_n and ser_ld are synchronous to clk.
module cfg_load_ctrl
    import divcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pl_n,
    input  logic [M_W-1:0]   par_m,
    input  logic [N_W-1:0]   par_n,
    input  logic             ser_ld,
    input  logic [FRAME_W-1:0] sr,
    output cfg_t             cfg_q
);
    logic pl_q;
    logic pin_load;
    logic ser_xfer;

    // Track the strobe one cycle back; during reset, follow it so that release creates no edge.
    always_ff @(posedge clk) begin
        pl_q <= pl_n;
    end

    assign pin_load = pl_n && !pl_q;
    assign ser_xfer = pl_n && pl_q && ser_ld;

    // Update the settings: pin capture first, then serial transfer, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (pin_load) begin
            cfg_q.m <= par_m;
            cfg_q.n <= par_n;
            cfg_q.t <= '0;
        end else if (ser_xfer) begin
            cfg_q <= cfg_t'(sr);
        end
    end

    AST_HOLD_STROBE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_n |=> $stable(cfg_q)); // R3
    AST_PIN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_n && !pl_q) |=> (cfg_q.m == $past(par_m) && cfg_q.n == $past(par_n) && cfg_q.t == '0)); // R2
    AST_SER_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_n && pl_q && ser_ld) |=> (cfg_q == cfg_t'($past(sr)))); // R5
    AST_SER_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_n && pl_q && !ser_ld) |=> $stable(cfg_q)); // R6
endmodule

// File: rtl/clk_out_gate.sv
// Output clock gating. A high master reset forces each true output low and
// each complementary output high. Assumes raw_clk comes from the divider counters.
module clk_out_gate #(
    parameter int NOUT = 2
) (
    input  logic            mreset,
    input  logic [NOUT-1:0] raw_clk,
    output logic [NOUT-1:0] fout,
    output logic [NOUT-1:0] fout_b
);
    // One gated differential pair per output.
    for (genvar i = 0; i < NOUT; i++) begin : g_pair
        assign fout[i]   = raw_clk[i] & ~mreset;
        assign fout_b[i] = ~(raw_clk[i] & ~mreset);
        always_comb begin
            if (mreset) AST_PAIR_HELD: assert (fout[i] == 1'b0 && fout_b[i] == 1'b1); // R9
        end
    end
endmodule

// File: rtl/divcfg_iface.sv
// Divider configuration top level. It joins the serial shift register, the
// active settings register and the output clock gating, and drives the test output.
// Assumes every control input is synchronous to clk.
module divcfg_iface
    import divcfg_pkg::*;
#(
    parameter int NOUT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pl_n,
    input  logic [8:0]      par_m,
    input  logic [1:0]      par_n,
    input  logic            ser_clk,
    input  logic            ser_dat,
    input  logic            ser_ld,
    input  logic            mreset,
    input  logic [NOUT-1:0] raw_clk,
    output logic [8:0]      m_val,
    output logic [1:0]      n_val,
    output logic [1:0]      t_val,
    output logic            test_out,
    output logic [NOUT-1:0] fout,
    output logic [NOUT-1:0] fout_b
);
    logic [FRAME_W-1:0] sr;
    cfg_t               cfg_q;

    cfg_shift_reg #(.W(FRAME_W)) u_sr (
        .clk(clk), .rst_n(rst_n), .ser_mode(pl_n),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .sr(sr)
    );

    cfg_load_ctrl u_ld (
        .clk(clk), .rst_n(rst_n), .pl_n(pl_n), .par_m(par_m), .par_n(par_n),
        .ser_ld(ser_ld), .sr(sr), .cfg_q(cfg_q)
    );

    clk_out_gate #(.NOUT(NOUT)) u_gate (
        .mreset(mreset), .raw_clk(raw_clk), .fout(fout), .fout_b(fout_b)
    );

    // Expose the settings and the end of the chain in serial mode.
    assign m_val    = cfg_q.m;
    assign n_val    = cfg_q.n;
    assign t_val    = cfg_q.t;
    assign test_out = pl_n & sr[FRAME_W-1];

    AST_MR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mreset && !pl_n) |=> $stable({t_val, n_val, m_val})); // R8
endmodule

// File: tb/tb_divcfg_iface.sv
module tb_divcfg_iface;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pl_n = 1'b1;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_ld = 1'b0;
    logic       mreset = 1'b0;
    logic [1:0] raw_clk = '0;
    logic [8:0] m_val;
    logic [1:0] n_val;
    logic [1:0] t_val;
    logic       test_out;
    logic [1:0] fout;
    logic [1:0] fout_b;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    divcfg_iface dut (
        .clk(clk), .rst_n(rst_n), .pl_n(pl_n), .par_m(par_m), .par_n(par_n),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld), .mreset(mreset),
        .raw_clk(raw_clk), .m_val(m_val), .n_val(n_val), .t_val(t_val),
        .test_out(test_out), .fout(fout), .fout_b(fout_b)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [12:0] frame(input logic [1:0] t, input logic [1:0] n, input logic [8:0] m);
        return {t, n, m};
    endfunction

    task automatic shift_frame(input logic [12:0] f);
        for (int i = 12; i >= 0; i--) begin
            @(negedge clk); ser_dat = f[i]; ser_clk = 1'b1;
            @(negedge clk); ser_clk = 1'b0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 m", m_val, 0); chk("R1 n", n_val, 0); chk("R1 t", t_val, 0);
        chk("R1 test_out", test_out, 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_serial();
        logic [12:0] f = frame(2'b10, 2'b01, 9'h15A);
        shift_frame(f);
        chk("R6 no transfer yet", {t_val, n_val, m_val}, 0);
        chk("R7 test_out msb", test_out, f[12]);
        ser_ld = 1'b1;
        @(negedge clk);
        chk("R4/R5 m", m_val, 9'h15A); chk("R4/R5 n", n_val, 2'b01); chk("R4/R5 t", t_val, 2'b10);
    endtask

    task automatic t_follow();
        logic [12:0] g = frame(2'b01, 2'b11, 9'h0C3);
        shift_frame(g);
        @(negedge clk);
        chk("R5 follow", {t_val, n_val, m_val}, g);
        ser_ld = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_idle_shift();
        logic [12:0] h = frame(2'b11, 2'b10, 9'h1F1);
        logic [12:0] g = frame(2'b01, 2'b11, 9'h0C3);
        shift_frame(h);
        chk("R6 hold", {t_val, n_val, m_val}, g);
    endtask

    task automatic t_parallel();
        @(negedge clk); par_m = 9'h0AA; par_n = 2'b10; pl_n = 1'b0;
        @(negedge clk);
        chk("R7 low in pin mode", test_out, 0);
        par_m = 9'h133; par_n = 2'b01;
        @(negedge clk);
        chk("R3 pins ignored", {t_val, n_val, m_val}, frame(2'b01, 2'b11, 9'h0C3));
        for (int i = 0; i < 13; i++) begin
            @(negedge clk); ser_dat = 1'b0; ser_clk = 1'b1;
            @(negedge clk); ser_clk = 1'b0;
        end
        par_m = 9'h07E; par_n = 2'b11;
        @(negedge clk); pl_n = 1'b1;
        @(negedge clk);
        chk("R2 m", m_val, 9'h07E); chk("R2 n", n_val, 2'b11); chk("R2 t", t_val, 0);
        chk("R10 sr kept test_out", test_out, 1);
        ser_ld = 1'b1;
        @(negedge clk); ser_ld = 1'b0;
        chk("R10 sr kept", {t_val, n_val, m_val}, frame(2'b11, 2'b10, 9'h1F1));
    endtask

    task automatic t_mreset();
        logic [12:0] cur = frame(2'b11, 2'b10, 9'h1F1);
        @(negedge clk); raw_clk = 2'b11; mreset = 1'b1;
        @(negedge clk);
        chk("R9 fout", fout, 2'b00); chk("R9 fout_b", fout_b, 2'b11);
        repeat (3) @(negedge clk);
        mreset = 1'b0; raw_clk = 2'b10;
        @(negedge clk);
        chk("R8 cfg kept", {t_val, n_val, m_val}, cur);
        chk("R9 pass fout", fout, 2'b10); chk("R9 pass fout_b", fout_b, 2'b01);
    endtask

    task automatic t_reset_again();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 clear cfg", {t_val, n_val, m_val}, 0);
        chk("R1 clear sr", test_out, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_serial();
        t_follow();
        t_idle_shift();
        t_parallel();
        t_mreset();
        t_reset_again();
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule